// File: doc/BRIEF.md
# Clocked Serial Master with Slave Busy Wait

This block is a byte-oriented serial master. It makes its own serial clock from the system clock. It shifts each byte out most significant bit first on a data-out pin and collects a byte from the data-in pin at the same time. Bytes to send arrive on a ready/valid load port. When a frame ends, the collected byte appears on a parallel output and a one-cycle interrupt pulse is raised.

Between frames the master lets a slave hold off the next transfer through a busy pin. The busy pin is asynchronous, so it first passes through a synchronizer. It is then looked at only once per serial period, at the point where the last rising clock edge of a frame falls and at whole periods after it. While busy reads active the serial clock rests high. Once busy reads inactive, the next frame begins on the falling edge half a period later, but only if a byte is offered at that moment. If no byte is offered, the master drops its active flag and goes idle. A select input sets the active level of busy.

Top module: `bsm_master`

## Requirements
- R1: A frame is 8 bits sent most significant bit first. The serial clock rests high. Each bit period is DIV system clocks: the clock is low for DIV/2 cycles and then high for DIV/2 cycles. Data out changes only as the serial clock falls.
- R2: Data in is captured as the serial clock rises, most significant bit first. The byte gathered this way is presented on rx_data in the same cycle in which frame_irq is high.
- R3: frame_irq is high for exactly one system cycle per completed frame. That cycle is the one after the last rising edge of the frame, and the serial clock is high in it.
- R4: At the last rising edge of a frame the synchronized busy level is examined. If it is inactive and a byte is offered, the next frame's first falling edge comes DIV/2 cycles after that rising edge.
- R5: If busy reads active at the end of a frame, the serial clock stays high and no frame starts. Busy is read again every DIV cycles, and the next falling edge comes DIV/2 cycles after the first inactive reading.
- R6: A busy release that lies entirely between two readings, and so is never read as inactive, does not start a frame. Only a later release that is read starts the frame.
- R7: With busy_pol at 0 the busy pin is active when high. With busy_pol at 1 it is active when low.
- R8: xfer_active is high while a frame shifts, while the master waits on busy, and during the half period before a launch. It falls DIV/2 cycles after the last rising edge when no byte is offered at the launch point. While it is low, sdo is low.
- R9: From idle, tx_ready is high. A byte offered with tx_valid is taken at once, and the serial clock falls in the next cycle whatever the busy level.
- R10: After reset, sck is 1, sdo is 0, xfer_active is 0, frame_irq is 0, rx_data is 0 and tx_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Master takes the offered byte on this edge |
| rx_data | output | 8 | Last byte received |
| xfer_active | output | 1 | Transfer or busy wait in progress |
| frame_irq | output | 1 | One-cycle pulse when a frame completes |
| busy_pol | input | 1 | Busy active level select (0: active high) |
| sck | output | 1 | Serial clock, rests high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy_in | input | 1 | Asynchronous busy from the slave |

## Verification
The bench measures the distance from the interrupt to the next falling edge. It does this with busy idle, with busy released partway through a wait, and with a short release placed between two readings. A master that polls busy every cycle, or that launches straight after the reading instead of half a period later, gives a gap that is off by a few cycles. A master that sees the short release starts a frame one period early. Polarity is tested both ways, so a design with the select inverted would either stall on an idle slave or run through a busy one. The bench also checks the end of a burst. It checks that the active flag drops at the launch point and that data out is low afterwards, which catches a master that keeps the last bit on the pin.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    localparam int FRAME_BITS = 8;

    typedef logic [FRAME_BITS-1:0] frame_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP,
        ST_WAIT
    } bsm_state_e;

    // busy level after polarity select: 1 means the slave holds us off
    function automatic logic busy_is_active(input logic lvl, input logic pol);
        return lvl ^ pol;
    endfunction

endpackage

// File: rtl/bsm_sync.sv
module bsm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    always_ff @(posedge clk) begin
        if (rst) ff_q <= '0;
        else     ff_q <= {ff_q[STAGES-2:0], d};
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/bsm_shreg.sv
module bsm_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {q[W-2:0], sin};
    end
endmodule

// File: rtl/bsm_master.sv
module bsm_master
    import bsm_pkg::*;
#(
    parameter int DIV         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [FRAME_BITS-1:0] tx_data,
    input  logic                  tx_valid,
    output logic                  tx_ready,
    output logic [FRAME_BITS-1:0] rx_data,
    output logic                  xfer_active,
    output logic                  frame_irq,
    input  logic                  busy_pol,
    output logic                  sck,
    output logic                  sdo,
    input  logic                  sdi,
    input  logic                  busy_in
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BW   = $clog2(FRAME_BITS);

    bsm_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] bit_q;
    logic          sck_q;
    logic          irq_q;
    frame_t        rx_q;

    logic   busy_lvl, busy_act;
    logic   at_half, at_end, last_bit;
    logic   launch_slot, take, rise_now, fall_mid;
    frame_t tx_sh, rx_sh, rx_next;

    bsm_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk (clk),
        .rst (rst),
        .d   (busy_in),
        .q   (busy_lvl)
    );

    assign busy_act = busy_is_active(busy_lvl, busy_pol);

    assign at_half  = (cnt_q == CW'(HALF - 1));
    assign at_end   = (cnt_q == CW'(DIV - 1));
    assign last_bit = (bit_q == BW'(FRAME_BITS - 1));

    // a byte may enter from idle, or at the falling-edge slot after a gap
    assign launch_slot = (state_q == ST_IDLE) || (state_q == ST_GAP && at_half);
    assign take        = launch_slot && tx_valid;
    assign rise_now    = (state_q == ST_SHIFT) && at_half;
    assign fall_mid    = (state_q == ST_SHIFT) && at_end;

    bsm_shreg #(.W(FRAME_BITS)) u_tx_sh (
        .clk      (clk),
        .rst      (rst),
        .load     (take),
        .load_val (tx_data),
        .shift    (fall_mid),
        .sin      (1'b0),
        .q        (tx_sh)
    );

    bsm_shreg #(.W(FRAME_BITS)) u_rx_sh (
        .clk      (clk),
        .rst      (rst),
        .load     (1'b0),
        .load_val ('0),
        .shift    (rise_now),
        .sin      (sdi),
        .q        (rx_sh)
    );

    assign rx_next = {rx_sh[FRAME_BITS-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sck_q   <= 1'b1;
            irq_q   <= 1'b0;
            rx_q    <= '0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (take) begin
                        state_q <= ST_SHIFT;
                        bit_q   <= '0;
                        sck_q   <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (rise_now) begin
                        sck_q <= 1'b1;
                        if (last_bit) begin
                            // frame complete: hand over byte, read busy once
                            irq_q   <= 1'b1;
                            rx_q    <= rx_next;
                            cnt_q   <= '0;
                            state_q <= busy_act ? ST_WAIT : ST_GAP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end else if (at_end) begin
                        cnt_q <= '0;
                        sck_q <= 1'b0;
                        bit_q <= bit_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (at_half) begin
                        cnt_q <= '0;
                        if (take) begin
                            state_q <= ST_SHIFT;
                            bit_q   <= '0;
                            sck_q   <= 1'b0;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (at_end) begin
                        cnt_q <= '0;
                        if (!busy_act) state_q <= ST_GAP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign tx_ready    = launch_slot;
    assign xfer_active = (state_q != ST_IDLE);
    assign frame_irq   = irq_q;
    assign rx_data     = rx_q;
    assign sck         = sck_q;
    assign sdo         = xfer_active & tx_sh[FRAME_BITS-1];

endmodule

// File: rtl/bsm_master_chk.sv
module bsm_master_chk
    import bsm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sck,
    input logic       sdo,
    input logic       xfer,
    input logic       irq,
    input logic       tx_valid,
    input logic       tx_ready,
    input bsm_state_e state
);
    p_idle_sdo_low_r8: assert property (@(posedge clk) disable iff (rst)
        !xfer |-> !sdo);

    p_idle_sck_high_r1: assert property (@(posedge clk) disable iff (rst)
        !xfer |-> sck);

    p_irq_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_irq_sck_high_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (sck && xfer));

    p_launch_fall_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> (!sck && xfer));

    p_wait_sck_high_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> (sck && xfer));

    p_wait_no_launch_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |=> (state != ST_SHIFT));
endmodule

bind bsm_master bsm_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sck      (sck),
    .sdo      (sdo),
    .xfer     (xfer_active),
    .irq      (frame_irq),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .state    (state_q)
);

// File: tb/bsm_master_bench.sv
module bsm_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;
    localparam int HALF       = DIV / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       xfer_active, frame_irq, sck, sdo;
    logic       busy_pol = 1'b0;
    logic       sdi = 1'b0;
    logic       busy_in = 1'b0;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    bsm_master #(.DIV(DIV)) u_bsm_master (
        .clk         (clk),
        .rst         (rst),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .rx_data     (rx_data),
        .xfer_active (xfer_active),
        .frame_irq   (frame_irq),
        .busy_pol    (busy_pol),
        .sck         (sck),
        .sdo         (sdo),
        .sdi         (sdi),
        .busy_in     (busy_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // port monitor, a quarter period after each rising system edge
    logic [7:0] slv    [0:15];
    logic [7:0] mon_tx [0:15];
    logic [7:0] mon_rx [0:15];
    int         gap_arr[0:15];
    logic [7:0] mon_sh = '0;
    logic       sck_prev = 1'b1, irq_prev = 1'b0, irq_pending = 1'b0;
    int rise_n = 0, fall_n = 0, nirq = 0, irq_cyc = 0;
    int last_rise = 0, last_fall = 0, period_err = 0, irq_long = 0;

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!rst) begin
            if (xfer_active !== 1'b1) irq_pending = 1'b0;
            if (sck === 1'b1 && sck_prev === 1'b0) begin
                if (cyc - last_fall != HALF) period_err++;
                mon_sh = {mon_sh[6:0], sdo};
                if (rise_n % 8 == 7) mon_tx[(rise_n / 8) % 16] = mon_sh;
                rise_n++;
                last_rise = cyc;
            end
            if (sck === 1'b0 && sck_prev === 1'b1) begin
                if (irq_pending) begin
                    gap_arr[(nirq - 1) % 16] = cyc - irq_cyc;
                    irq_pending = 1'b0;
                end else if (rise_n % 8 != 0) begin
                    if (cyc - last_rise != HALF) period_err++;
                end
                sdi = slv[(fall_n / 8) % 16][7 - (fall_n % 8)];
                fall_n++;
                last_fall = cyc;
            end
            if (frame_irq === 1'b1) begin
                if (irq_prev) irq_long++;
                else begin
                    mon_rx[nirq % 16] = rx_data;
                    nirq++;
                    irq_cyc = cyc;
                    irq_pending = 1'b1;
                end
            end
            irq_prev = frame_irq;
            sck_prev = sck;
        end
    end

    task automatic chk_eq(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        tx_data  = b;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_irqs(input int target);
        while (nirq < target) @(negedge clk);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R10 sck after reset", sck, 1);
        chk_eq("R10 sdo after reset", sdo, 0);
        chk_eq("R10 xfer_active after reset", xfer_active, 0);
        chk_eq("R10 frame_irq after reset", frame_irq, 0);
        chk_eq("R10 rx_data after reset", rx_data, 0);
        chk_eq("R10 tx_ready after reset", tx_ready, 1);
    endtask

    // R1 R2 R3 R8: one byte, then idle
    task automatic t_single;
        int base = nirq;
        slv[base % 16] = 8'h3C;
        send(8'hA5);
        wait_irqs(base + 1);
        wait_cyc(irq_cyc + HALF - 1);
        chk_eq("R8 xfer_active held before launch point", xfer_active, 1);
        wait_cyc(irq_cyc + HALF);
        chk_eq("R8 xfer_active falls at launch point", xfer_active, 0);
        chk_eq("R8 sdo low when idle", sdo, 0);
        chk_eq("R1 sck rests high", sck, 1);
        chk_eq("R1 byte on sdo msb first", mon_tx[base % 16], 8'hA5);
        chk_eq("R2 byte from sdi on rx_data", mon_rx[base % 16], 8'h3C);
        chk_eq("R1 bit period halves", period_err, 0);
        chk_eq("R3 irq pulse length", irq_long, 0);
        chk_eq("R3 one irq per frame", nirq - base, 1);
    endtask

    // R4: three bytes queued, busy inactive
    task automatic t_b2b;
        int base = nirq;
        logic [7:0] tb [0:2] = '{8'h81, 8'h5A, 8'hFF};
        logic [7:0] sb [0:2] = '{8'h01, 8'hC3, 8'h70};
        for (int i = 0; i < 3; i++) slv[(base + i) % 16] = sb[i];
        busy_in = 1'b0;
        fork
            begin
                for (int i = 0; i < 3; i++) send(tb[i]);
            end
            wait_irqs(base + 3);
        join
        wait_cyc(irq_cyc + HALF + 1);
        for (int i = 0; i < 3; i++) begin
            chk_eq("R1 back-to-back tx byte", mon_tx[(base + i) % 16], tb[i]);
            chk_eq("R2 back-to-back rx byte", mon_rx[(base + i) % 16], sb[i]);
        end
        chk_eq("R4 gap after frame 0", gap_arr[base % 16], HALF);
        chk_eq("R4 gap after frame 1", gap_arr[(base + 1) % 16], HALF);
        chk_eq("R1 bit period halves in burst", period_err, 0);
        chk_eq("R3 irq pulse length in burst", irq_long, 0);
    endtask

    // R5 R9: busy active before the first byte, released 10 cycles after frame end
    task automatic t_busy_wait;
        int base = nirq;
        slv[base % 16] = 8'h12;
        slv[(base + 1) % 16] = 8'h34;
        busy_in = 1'b1;
        repeat (4) @(negedge clk);
        fork
            begin
                send(8'h9E);
                send(8'h47);
            end
            begin
                wait_irqs(base + 1);
                wait_cyc(irq_cyc + 6);
                chk_eq("R5 sck high during wait", sck, 1);
                wait_cyc(irq_cyc + 10);
                busy_in = 1'b0;
            end
            wait_irqs(base + 2);
        join
        wait_cyc(irq_cyc + HALF + 1);
        chk_eq("R9 first frame ran while busy", mon_tx[base % 16], 8'h9E);
        chk_eq("R5 gap with wait", gap_arr[base % 16], HALF + 2 * DIV);
        chk_eq("R5 second byte after wait", mon_tx[(base + 1) % 16], 8'h47);
        chk_eq("R2 rx after wait", mon_rx[(base + 1) % 16], 8'h34);
    endtask

    // R6: a three-cycle release between readings is missed
    task automatic t_short_release;
        int base = nirq;
        slv[base % 16] = 8'hE7;
        slv[(base + 1) % 16] = 8'h18;
        busy_in = 1'b1;
        fork
            begin
                send(8'h66);
                send(8'hB9);
            end
            begin
                wait_irqs(base + 1);
                wait_cyc(irq_cyc + 10);
                busy_in = 1'b0;
                wait_cyc(irq_cyc + 13);
                busy_in = 1'b1;
                wait_cyc(irq_cyc + 2 * DIV + HALF);
                chk_eq("R6 no frame after missed release", sck, 1);
                wait_cyc(irq_cyc + 20);
                busy_in = 1'b0;
            end
            wait_irqs(base + 2);
        join
        wait_cyc(irq_cyc + HALF + 1);
        chk_eq("R6 gap after short pulse", gap_arr[base % 16], HALF + 3 * DIV);
        chk_eq("R6 second byte", mon_tx[(base + 1) % 16], 8'hB9);
    endtask

    // R7: active-low busy, then idle-high level with no wait
    task automatic t_polarity;
        int base = nirq;
        busy_pol = 1'b1;
        busy_in  = 1'b0;
        for (int i = 0; i < 4; i++) slv[(base + i) % 16] = 8'(8'h21 * (i + 1));
        repeat (4) @(negedge clk);
        fork
            begin
                send(8'hC0);
                send(8'h0D);
            end
            begin
                wait_irqs(base + 1);
                wait_cyc(irq_cyc + 10);
                busy_in = 1'b1;
            end
            wait_irqs(base + 2);
        join
        wait_cyc(irq_cyc + HALF + 1);
        chk_eq("R7 low level holds off when pol=1", gap_arr[base % 16], HALF + 2 * DIV);
        fork
            begin
                send(8'h77);
                send(8'h88);
            end
            wait_irqs(base + 4);
        join
        wait_cyc(irq_cyc + HALF + 1);
        chk_eq("R7 high level releases when pol=1", gap_arr[(base + 2) % 16], HALF);
        chk_eq("R7 byte after release", mon_tx[(base + 3) % 16], 8'h88);
        chk_eq("R2 rx with pol=1", mon_rx[(base + 3) % 16], 8'h84);
        chk_eq("R8 idle after burst", xfer_active, 0);
        busy_pol = 1'b0;
        busy_in  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            slv[i] = '0;
            mon_tx[i] = '0;
            mon_rx[i] = '0;
            gap_arr[i] = 0;
        end
        @(negedge clk);
        t_reset();
        t_single();
        t_b2b();
        t_busy_wait();
        t_short_release();
        t_polarity();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule